// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block collects error indications from surrounding hardware into a bank of 64-bit registers. Software reaches the bank through a simple register port at 8-byte granularity. The fault register records which error sources have fired. The mask register hides chosen faults from the alert outputs. Two action registers give every unmasked fault one of three alert classes, or none. A first-error register keeps the set of fault bits that appeared first since software last cleared it.

Software changes single bits without a read-modify-write. Both the fault register and the mask register have three write addresses: a direct load, an AND alias (zero bits clear) and an OR alias (one bits set). Any write to the first-error register empties it, whatever the data. A report register and a status register can be read but ignore writes. A reset-control register keeps only its top bit. Hardware error pulses set fault bits and take priority over a software write in the same cycle.

Top module: `fir_bank`

## Requirements
- R1: After reset, every register reads zero and all three alert outputs are low.
- R2: A write to word 0 (fault) replaces the fault register, and a read of word 0 returns it on the cycle after the read request.
- R3: A write to word 1 ANDs the data into the fault register, so each zero data bit clears that fault bit.
- R4: A write to word 2 ORs the data into the fault register, so each one data bit sets that fault bit.
- R5: The mask register has the same three writes: direct load at word 3, AND at word 4, OR at word 5.
- R6: Action register 0 (word 6) and action register 1 (word 7) are plain read/write registers.
- R7: A one on hw_err bit i sets fault bit i. When this coincides with a software write that would clear the bit, the bit still ends up set.
- R8: While the first-error register (word 8) is zero, it takes the fault bits that go from 0 to 1 in a cycle. Once it is non-zero it holds that value.
- R9: Any write to word 8 clears the first-error register to zero, regardless of the data.
- R10: For each fault bit that is set and not masked, the pair (action0 bit, action1 bit) selects the alert: 00 raises alert_chkstop, 01 raises alert_recov, 10 raises alert_attn, 11 raises none. Each output is the OR over all bits.
- R11: Word 9 reads fault AND NOT mask. Word 10 reads the alert outputs in bit 0 (chkstop), bit 1 (recov) and bit 2 (attn). Writes to these two words have no effect.
- R12: A write to word 11 (reset control) keeps only data bit 63. A read of word 11 returns that bit in position 63 and zeros elsewhere.
- R13: An access to a word above 11, or to an address whose low three bits are not zero, changes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe for one cycle |
| bus_ren | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address; word index = bits [ADDR_W-1:3] |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after bus_ren |
| hw_err | input | N_FLT | Hardware error pulses, one per fault bit |
| alert_chkstop | output | 1 | Checkstop class alert |
| alert_recov | output | 1 | Recoverable class alert |
| alert_attn | output | 1 | Attention class alert |

## Verification
The assertions watch several rules on every cycle. A hardware error pulse always leaves its fault bit set on the next cycle. An AND or OR write leaves only the permitted bits. An idle register holds its value. A non-empty first-error value stays fixed until it is written, and a write always empties it. No alert rises unless some unmasked fault has a class other than "none". Some behaviour only the directed scenarios can show: the exact read-back values, the software-visible result of a hardware set racing a direct clearing write, which bits the first-error register captures, the class each action pair selects, and that writes to read-only, reserved or misaligned addresses leave the visible state untouched.

// File: rtl/fir_pkg.sv
package fir_pkg;

  localparam int REG_W    = 64;
  localparam int RSTC_BIT = 63;

  typedef enum logic [3:0] {
    IDX_FLT     = 4'd0,
    IDX_FLT_AND = 4'd1,
    IDX_FLT_OR  = 4'd2,
    IDX_MSK     = 4'd3,
    IDX_MSK_AND = 4'd4,
    IDX_MSK_OR  = 4'd5,
    IDX_ACT0    = 4'd6,
    IDX_ACT1    = 4'd7,
    IDX_FIRST   = 4'd8,
    IDX_RPT     = 4'd9,
    IDX_STAT    = 4'd10,
    IDX_RSTC    = 4'd11
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_AND  = 2'd2,
    OP_OR   = 2'd3
  } upd_op_e;

  // Software update of a register: load, AND-clear or OR-set.
  function automatic logic [REG_W-1:0] apply_op(upd_op_e op,
                                                logic [REG_W-1:0] cur,
                                                logic [REG_W-1:0] d);
    case (op)
      OP_LOAD: apply_op = d;
      OP_AND:  apply_op = cur & d;
      OP_OR:   apply_op = cur | d;
      default: apply_op = cur;
    endcase
  endfunction

endpackage

// File: rtl/fir_upd_reg.sv
module fir_upd_reg
  import fir_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  upd_op_e      op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);

  logic [REG_W-1:0] cur64, dat64, sw64;
  logic [W-1:0]     nxt;

  always_comb begin
    cur64        = '0;
    dat64        = '0;
    cur64[W-1:0] = q;
    dat64[W-1:0] = wdata;
    sw64         = apply_op(op, cur64, dat64);
    nxt          = sw64[W-1:0] | hw_set;   // hardware set has priority
    rise         = nxt & ~q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R7: a hardware pulse leaves its bit set on the next cycle
  p_hw_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

  // R4 (and R5 for the mask instance): OR write sets every data bit
  p_or_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_OR) |=> ((q & $past(wdata)) == $past(wdata)));

  // R3 (and R5 for the mask instance): AND write leaves no bit outside data|hw
  p_and_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND) |=> ((q & ~($past(wdata) | $past(hw_set))) == '0));

  // R2: with no write and no hardware event the register holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE && hw_set == '0) |=> $stable(q));

endmodule

// File: rtl/fir_classify.sv
module fir_classify #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] act0,
  input  logic [W-1:0] act1,
  output logic         chkstop,
  output logic         recov,
  output logic         attn
);

  logic [W-1:0] cls_chk, cls_rec, cls_att;

  always_comb begin
    cls_chk = pend & ~act0 & ~act1;   // 00
    cls_rec = pend & ~act0 &  act1;   // 01
    cls_att = pend &  act0 & ~act1;   // 10
    chkstop = |cls_chk;
    recov   = |cls_rec;
    attn    = |cls_att;
  end

  // R10: if every pending fault is of class "none", no alert is raised
  p_none_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~(act0 & act1)) == '0) |-> !(chkstop || recov || attn));

endmodule

// File: rtl/fir_bank.sv
module fir_bank
  import fir_pkg::*;
#(
  parameter int N_FLT  = 64,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N_FLT-1:0]  hw_err,
  output logic              alert_chkstop,
  output logic              alert_recov,
  output logic              alert_attn
);

  localparam int IDX_W    = ADDR_W - 3;
  localparam int LAST_IDX = 11;

  logic [IDX_W-1:0] idx;
  logic             hit;
  reg_idx_e         sel;
  logic             wr_hit, rd_hit, wr_first;
  upd_op_e          flt_op, msk_op;

  logic [N_FLT-1:0] flt_q, msk_q, act0_q, act1_q, first_q;
  logic [N_FLT-1:0] flt_rise, msk_rise, pend;
  logic             rstc_q;
  logic [REG_W-1:0] rd_val;

  function automatic logic [REG_W-1:0] zext(logic [N_FLT-1:0] v);
    zext            = '0;
    zext[N_FLT-1:0] = v;
  endfunction

  assign idx      = bus_addr[ADDR_W-1:3];
  assign hit      = (bus_addr[2:0] == 3'b000) && (idx <= IDX_W'(LAST_IDX));
  assign sel      = reg_idx_e'(idx[3:0]);
  assign wr_hit   = bus_wen && hit;
  assign rd_hit   = bus_ren && hit;
  assign wr_first = wr_hit && (sel == IDX_FIRST);

  always_comb begin
    flt_op = OP_NONE;
    msk_op = OP_NONE;
    if (wr_hit) begin
      case (sel)
        IDX_FLT:     flt_op = OP_LOAD;
        IDX_FLT_AND: flt_op = OP_AND;
        IDX_FLT_OR:  flt_op = OP_OR;
        IDX_MSK:     msk_op = OP_LOAD;
        IDX_MSK_AND: msk_op = OP_AND;
        IDX_MSK_OR:  msk_op = OP_OR;
        default:     ;
      endcase
    end
  end

  fir_upd_reg #(.W(N_FLT)) u_fault (
    .clk(clk), .rst_n(rst_n), .op(flt_op), .wdata(bus_wdata[N_FLT-1:0]),
    .hw_set(hw_err), .q(flt_q), .rise(flt_rise)
  );

  fir_upd_reg #(.W(N_FLT)) u_mask (
    .clk(clk), .rst_n(rst_n), .op(msk_op), .wdata(bus_wdata[N_FLT-1:0]),
    .hw_set('0), .q(msk_q), .rise(msk_rise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act0_q  <= '0;
      act1_q  <= '0;
      first_q <= '0;
      rstc_q  <= 1'b0;
    end else begin
      if (wr_hit && sel == IDX_ACT0) act0_q <= bus_wdata[N_FLT-1:0];
      if (wr_hit && sel == IDX_ACT1) act1_q <= bus_wdata[N_FLT-1:0];
      if (wr_hit && sel == IDX_RSTC) rstc_q <= bus_wdata[RSTC_BIT];
      if (wr_first)                  first_q <= '0;
      else if (first_q == '0)        first_q <= flt_rise;
    end
  end

  assign pend = flt_q & ~msk_q;

  fir_classify #(.W(N_FLT)) u_class (
    .clk(clk), .rst_n(rst_n), .pend(pend), .act0(act0_q), .act1(act1_q),
    .chkstop(alert_chkstop), .recov(alert_recov), .attn(alert_attn)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      IDX_FLT, IDX_FLT_AND, IDX_FLT_OR: rd_val = zext(flt_q);
      IDX_MSK, IDX_MSK_AND, IDX_MSK_OR: rd_val = zext(msk_q);
      IDX_ACT0:  rd_val = zext(act0_q);
      IDX_ACT1:  rd_val = zext(act1_q);
      IDX_FIRST: rd_val = zext(first_q);
      IDX_RPT:   rd_val = zext(pend);
      IDX_STAT:  rd_val = {{(REG_W-3){1'b0}}, alert_attn, alert_recov, alert_chkstop};
      IDX_RSTC:  rd_val[RSTC_BIT] = rstc_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_hit ? rd_val : '0;
  end

  // R9: a write to the first-error word empties it
  p_first_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_first |=> (first_q == '0));

  // R8: a captured first-error value holds until it is written
  p_first_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q != '0 && !wr_first) |=> $stable(first_q));

  // R5: the mask never changes without a mask write
  p_mask_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_op == OP_NONE) |=> $stable(msk_q));

endmodule

// File: tb/fir_bank_bench.sv
module fir_bank_bench;

  localparam int NF = 64;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wen, bus_ren;
  logic [AW-1:0] bus_addr;
  logic [63:0]   bus_wdata, bus_rdata;
  logic [NF-1:0] hw_err;
  logic          alert_chkstop, alert_recov, alert_attn;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] rv;

  always #2 clk = ~clk;   // 250 MHz

  fir_bank #(.N_FLT(NF), .ADDR_W(AW)) u_fir_bank (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_err(hw_err), .alert_chkstop(alert_chkstop),
    .alert_recov(alert_recov), .alert_attn(alert_attn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int word, input logic [63:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = AW'(word * 8); bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int word, output logic [63:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = AW'(word * 8);
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [63:0] alerts();
    return {61'b0, alert_attn, alert_recov, alert_chkstop};
  endfunction

  task automatic t_reset();
    rd(0, rv);  check("R1 fault", rv, 64'h0);
    rd(3, rv);  check("R1 mask", rv, 64'h0);
    rd(6, rv);  check("R1 act0", rv, 64'h0);
    rd(8, rv);  check("R1 first", rv, 64'h0);
    rd(11, rv); check("R1 rstc", rv, 64'h0);
    check("R1 alerts", alerts(), 64'h0);
  endtask

  task automatic t_fault_writes();
    wr(0, 64'hF0F0_1234_0000_00FF); rd(0, rv);
    check("R2 load", rv, 64'hF0F0_1234_0000_00FF);
    wr(1, 64'h00FF_FFFF_0000_000F); rd(0, rv);
    check("R3 and", rv, 64'h00F0_1234_0000_000F);
    wr(2, 64'h8000_0000_0000_0100); rd(2, rv);
    check("R4 or", rv, 64'h80F0_1234_0000_010F);
    wr(0, 64'h0);
  endtask

  task automatic t_mask_writes();
    wr(3, 64'h0000_FFFF_0000_FFFF); rd(3, rv);
    check("R5 load", rv, 64'h0000_FFFF_0000_FFFF);
    wr(4, 64'h0000_00FF_FFFF_FF00); rd(4, rv);
    check("R5 and", rv, 64'h0000_00FF_0000_FF00);
    wr(5, 64'hA000_0000_0000_0001); rd(5, rv);
    check("R5 or", rv, 64'hA000_00FF_0000_FF01);
    wr(3, 64'h0);
  endtask

  task automatic t_actions();
    wr(6, 64'h0123_4567_89AB_CDEF);
    wr(7, 64'hFEDC_BA98_7654_3210);
    rd(6, rv); check("R6 act0", rv, 64'h0123_4567_89AB_CDEF);
    rd(7, rv); check("R6 act1", rv, 64'hFEDC_BA98_7654_3210);
    wr(6, 64'h0); wr(7, 64'h0);
  endtask

  task automatic t_hw_set();
    wr(0, 64'h0);
    @(negedge clk); hw_err = 64'h20;
    @(negedge clk); hw_err = '0;
    rd(0, rv); check("R7 pulse", rv, 64'h20);
    // hardware set racing a direct clearing write
    @(negedge clk);
    hw_err = 64'h200; bus_wen = 1'b1; bus_addr = AW'(0); bus_wdata = 64'h0;
    @(negedge clk);
    hw_err = '0; bus_wen = 1'b0;
    rd(0, rv); check("R7 race load", rv, 64'h200);
    // racing an AND clear
    @(negedge clk);
    hw_err = 64'h200; bus_wen = 1'b1; bus_addr = AW'(8); bus_wdata = 64'h0;
    @(negedge clk);
    hw_err = '0; bus_wen = 1'b0;
    rd(0, rv); check("R7 race and", rv, 64'h200);
    wr(0, 64'h0);
  endtask

  task automatic t_first();
    wr(0, 64'h0);
    wr(8, 64'h0);
    rd(8, rv); check("R9 cleared", rv, 64'h0);
    wr(2, 64'h30);
    rd(8, rv); check("R8 capture", rv, 64'h30);
    @(negedge clk); hw_err = 64'h2;
    @(negedge clk); hw_err = '0;
    rd(8, rv); check("R8 hold", rv, 64'h30);
    rd(0, rv); check("R8 fault", rv, 64'h32);
    wr(8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8, rv); check("R9 any data", rv, 64'h0);
    @(negedge clk); hw_err = 64'h4;
    @(negedge clk); hw_err = '0;
    rd(8, rv); check("R8 recapture", rv, 64'h4);
    wr(0, 64'h0); wr(8, 64'h0);
  endtask

  task automatic t_classify();
    wr(6, 64'hC);   // bits 2,3
    wr(7, 64'hA);   // bits 1,3
    wr(0, 64'hF);
    check("R10 all classes", alerts(), 64'h7);
    rd(10, rv); check("R11 status", rv, 64'h7);
    wr(5, 64'h1);
    check("R10 chk masked", alerts(), 64'h6);
    wr(5, 64'h6);
    check("R10 only none pending", alerts(), 64'h0);
    rd(9, rv); check("R11 report", rv, 64'h8);
    wr(3, 64'h0); wr(0, 64'h2);
    check("R10 recov only", alerts(), 64'h2);
    wr(0, 64'h0); wr(6, 64'h0); wr(7, 64'h0);
    check("R10 idle", alerts(), 64'h0);
  endtask

  task automatic t_readonly();
    wr(0, 64'h0F00); wr(3, 64'h0300);
    wr(9, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(10, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, rv); check("R11 fault kept", rv, 64'h0F00);
    rd(3, rv); check("R11 mask kept", rv, 64'h0300);
    rd(9, rv); check("R11 report value", rv, 64'h0C00);
    wr(12, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_raw(AW'(3), 64'hFFFF_FFFF_FFFF_FFFF);   // misaligned word 0
    rd(0, rv); check("R13 fault kept", rv, 64'h0F00);
    rd(12, rv); check("R13 reserved read", rv, 64'h0);
    wr(0, 64'h0); wr(3, 64'h0);
  endtask

  task automatic t_rstc();
    wr(11, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(11, rv); check("R12 keep top", rv, 64'h8000_0000_0000_0000);
    wr(11, 64'h7FFF_FFFF_FFFF_FFFF);
    rd(11, rv); check("R12 clear top", rv, 64'h0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wen = 1'b0; bus_ren = 1'b0;
    bus_addr = '0; bus_wdata = '0; hw_err = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fault_writes();
    t_mask_writes();
    t_actions();
    t_hw_set();
    t_first();
    t_classify();
    t_readonly();
    t_rstc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule